// File: doc/BRIEF.md
# Replicated Register Bank with Steered Access

This block holds a small set of control registers, each of which exists as many physical copies: one per hardware unit, the units being arranged as groups of instances. All copies of one register answer to a single bus address. A steering selector register, reachable on the same bus, names the group and the instance that an access is aimed at. It also carries a multicast flag that decides whether a write fans out to every copy or lands on the steered copy alone. Reads never fan out: they always return the steered copy.

A per-copy presence vector models units that are fused off or powered down. An access aimed at an absent copy terminates. A read then returns zero and a unicast write has no effect. A multicast write simply skips the absent copies. Software agents that share the selector serialize through a steering semaphore. Reading the semaphore while it is free returns 1 and takes it. Reading it while it is held returns 0. Writing 1 to it frees it.

The bus is a single-cycle read/write port. Writes take effect at the clock edge where they are presented. A read returns its data, with a valid strobe, in the following cycle.

Top module: `repl_reg_bank`

## Requirements
- R1: The word address map is fixed: selector at address 0, semaphore at address 1, and replicated register r at address 2+r for r below NUM_REGS. Any other address reads as zero and ignores writes.
- R2: The selector holds a group field in bits 3:0, an instance field in bits 7:4 and the multicast flag in bit 31. Other bits read as zero. After reset the selector reads 0x8000_0000.
- R3: With the multicast flag set, a write to a replicated register stores the data into every present copy of that register.
- R4: With the multicast flag clear, a write stores the data into the steered copy only. Every other copy keeps its value.
- R5: A read of a replicated register returns the steered copy, whatever the state of the multicast flag.
- R6: The steered copy is absent when its presence bit (index group*NUM_INST+instance) is 0, or when the group or instance field is out of range. A read of an absent copy returns 0, and a unicast write to it is dropped.
- R7: A multicast write leaves absent copies unchanged. Their old value is seen again once they become present.
- R8: The semaphore resets free. A read while it is free returns 1 and takes it. A read while it is held returns 0. A write with bit 0 set frees it, and a write with bit 0 clear has no effect.
- R9: rd_valid is high exactly in the cycle after a cycle with bus_rd high, and rd_data carries the read result in that cycle. A read issued in the cycle after a write sees that write.
- R10: After reset every copy of every replicated register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| present_mask | input | NUM_GROUPS*NUM_INST | Per-copy presence, 1 = unit present |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| rd_data | output | DATA_W | Read data, zero when rd_valid is low |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, and that present_mask changes only between accesses and not while a read is in flight. The stimulus keeps to these rules because each access is a single task that raises one strobe for one cycle. The presence vector is changed only from the test body, between tasks. The assertions also assume that a semaphore release write and a semaphore read never coincide. This holds because the stimulus is serialized through those same tasks.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int FIELD_W      = 4;
  localparam int SEL_GRP_LSB  = 0;
  localparam int SEL_INST_LSB = 4;
  localparam int ADDR_SEL     = 0;
  localparam int ADDR_SEM     = 1;
  localparam int ADDR_REG0    = 2;
endpackage

// File: rtl/rrb_selector.sv
module rrb_selector
  import rrb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int INST_CNT   = 16,
  parameter int IDX_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [FIELD_W-1:0]   wr_grp,
  input  logic [FIELD_W-1:0]   wr_inst,
  input  logic                 wr_mc,
  input  logic [INST_CNT-1:0]  present_mask,
  output logic [DATA_W-1:0]    sel_rdata,
  output logic                 mcast,
  output logic [IDX_W-1:0]     steer_idx,
  output logic                 steer_live
);
  localparam int PAD_W = DATA_W - 1 - 2 * FIELD_W;

  logic [FIELD_W-1:0] grp_q, inst_q;
  logic               mc_q;
  logic [31:0]        idx_full;
  logic               in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q  <= '0;
      inst_q <= '0;
      mc_q   <= 1'b1;
    end else if (wr_en) begin
      grp_q  <= wr_grp;
      inst_q <= wr_inst;
      mc_q   <= wr_mc;
    end
  end

  always_comb begin
    idx_full   = 32'(grp_q) * 32'(NUM_INST) + 32'(inst_q);
    in_range   = (32'(grp_q) < 32'(NUM_GROUPS)) && (32'(inst_q) < 32'(NUM_INST));
    steer_idx  = IDX_W'(idx_full);
    steer_live = in_range && present_mask[steer_idx];
    mcast      = mc_q;
    sel_rdata  = {mc_q, {PAD_W{1'b0}}, inst_q, grp_q};
  end

  // R2: a selector write is reflected in the following cycle
  a_r2_sel_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (sel_rdata[7:0] == {$past(wr_inst), $past(wr_grp)}) && (mcast == $past(wr_mc)));

  // R6: an absent steered copy is never reported live
  a_r6_absent_not_live: assert property (@(posedge clk) disable iff (rst)
    (in_range && !present_mask[steer_idx]) |-> !steer_live);
endmodule

// File: rtl/rrb_semaphore.sv
module rrb_semaphore (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wbit,
  output logic rd_bit
);
  logic held_q;

  always_ff @(posedge clk) begin
    if (rst)                held_q <= 1'b0;
    else if (wr_en && wbit) held_q <= 1'b0;
    else if (rd_en)         held_q <= 1'b1;
  end

  assign rd_bit = !held_q;

  // R8: a contending read never frees the semaphore
  a_r8_hold_on_contend: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_bit && !wr_en) |=> !rd_bit);

  // R8: a grant leaves the semaphore held
  a_r8_grant_takes: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_bit && !wr_en) |=> !rd_bit);

  // R8: writing 1 frees it
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wbit) |=> rd_bit);
endmodule

// File: rtl/rrb_inst_array.sv
module rrb_inst_array #(
  parameter int DATA_W   = 32,
  parameter int INST_CNT = 16,
  parameter int IDX_W    = 4,
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_reg,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                mcast,
  input  logic [IDX_W-1:0]    steer_idx,
  input  logic                steer_live,
  input  logic [INST_CNT-1:0] present_mask,
  input  logic [REG_W-1:0]    rd_reg,
  output logic [DATA_W-1:0]   rd_word
);
  logic [DATA_W-1:0]            store [NUM_REGS][INST_CNT];
  logic [NUM_REGS*INST_CNT-1:0] we;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar k = 0; k < INST_CNT; k++) begin : g_inst
      localparam int FLAT = r * INST_CNT + k;

      assign we[FLAT] = wr_en && (wr_reg == REG_W'(r)) && present_mask[k] &&
                        (mcast || (steer_live && (steer_idx == IDX_W'(k))));

      always_ff @(posedge clk) begin
        if (rst)           store[r][k] <= '0;
        else if (we[FLAT]) store[r][k] <= wdata;
      end

      // R3: multicast write reaches every present copy
      a_r3_mcast_all: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mcast && (wr_reg == REG_W'(r)) && present_mask[k])
        |=> (store[r][k] == $past(wdata)));

      // R7: an absent copy keeps its value
      a_r7_absent_kept: assert property (@(posedge clk) disable iff (rst)
        !present_mask[k] |=> $stable(store[r][k]));
    end
  end

  assign rd_word = steer_live ? store[rd_reg][steer_idx] : '0;

  // R4: a unicast write touches at most one copy
  a_r4_unicast_single: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mcast) |-> $onehot0(we));
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank
  import rrb_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int NUM_REGS   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_GROUPS*NUM_INST-1:0] present_mask,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int INST_CNT = NUM_GROUPS * NUM_INST;
  localparam int IDX_W    = (INST_CNT > 1) ? $clog2(INST_CNT) : 1;
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic              sel_hit, sem_hit, reg_hit;
  logic [REG_W-1:0]  reg_idx;
  logic [DATA_W-1:0] sel_rdata, rd_word, rd_mux;
  logic              mcast, steer_live, sem_bit;
  logic [IDX_W-1:0]  steer_idx;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    sel_hit = (bus_addr == ADDR_W'(ADDR_SEL));
    sem_hit = (bus_addr == ADDR_W'(ADDR_SEM));
    reg_hit = (32'(bus_addr) >= 32'(ADDR_REG0)) &&
              (32'(bus_addr) <  32'(ADDR_REG0 + NUM_REGS));
    reg_idx = REG_W'(32'(bus_addr) - 32'(ADDR_REG0));
  end

  rrb_selector #(
    .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST),
    .INST_CNT(INST_CNT), .IDX_W(IDX_W)
  ) u_sel (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && sel_hit),
    .wr_grp(bus_wdata[SEL_GRP_LSB +: FIELD_W]),
    .wr_inst(bus_wdata[SEL_INST_LSB +: FIELD_W]),
    .wr_mc(bus_wdata[DATA_W-1]),
    .present_mask(present_mask),
    .sel_rdata(sel_rdata), .mcast(mcast),
    .steer_idx(steer_idx), .steer_live(steer_live)
  );

  rrb_semaphore u_sem (
    .clk(clk), .rst(rst),
    .rd_en(bus_rd && sem_hit),
    .wr_en(bus_wr && sem_hit),
    .wbit(bus_wdata[0]),
    .rd_bit(sem_bit)
  );

  rrb_inst_array #(
    .DATA_W(DATA_W), .INST_CNT(INST_CNT), .IDX_W(IDX_W),
    .NUM_REGS(NUM_REGS), .REG_W(REG_W)
  ) u_arr (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && reg_hit), .wr_reg(reg_idx), .wdata(bus_wdata),
    .mcast(mcast), .steer_idx(steer_idx), .steer_live(steer_live),
    .present_mask(present_mask), .rd_reg(reg_idx), .rd_word(rd_word)
  );

  always_comb begin
    if (sel_hit)      rd_mux = sel_rdata;
    else if (sem_hit) rd_mux = {{(DATA_W-1){1'b0}}, sem_bit};
    else if (reg_hit) rd_mux = rd_word;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= bus_rd;
      data_q  <= bus_rd ? rd_mux : '0;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // R9: the strobe follows a read by one cycle
  a_r9_valid_timing: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd));

  // R9: read data is zero outside valid cycles
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R6: a terminated read returns zero
  a_r6_term_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && reg_hit && !steer_live) |=> (rd_data == '0));

  // R1: an unmapped read returns zero
  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_hit && !sem_hit && !reg_hit) |=> (rd_data == '0));
endmodule

// File: tb/repl_reg_bank_tb.sv
module repl_reg_bank_tb;
  localparam int NG = 4, NI = 4, NC = NG * NI, NR = 2, AW = 4, DW = 32;

  logic          clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [NC-1:0] present = '1;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  repl_reg_bank #(.DATA_W(DW), .ADDR_W(AW), .NUM_GROUPS(NG), .NUM_INST(NI), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .present_mask(present), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NR][NC];

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bwrite(int a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
    if (rd_valid !== 1'b1) check("R9 rd_valid", 32'(rd_valid), 32'd1);
  endtask

  function automatic logic [DW-1:0] steer(int g, int i, bit mc);
    return {mc, 23'b0, 4'(i), 4'(g)};
  endfunction

  function automatic logic [DW-1:0] expv(int r, int g, int i);
    if (g < NG && i < NI && present[g*NI+i]) return model[r][g*NI+i];
    return '0;
  endfunction

  task automatic read_inst(string tag, int r, int g, int i, bit mc);
    logic [DW-1:0] d;
    bwrite(0, steer(g, i, mc));
    bread(2 + r, d);
    check(tag, d, expv(r, g, i));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000 * 7) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NC; k++) model[r][k] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle valid", 32'(rd_valid), 32'd0);
    bread(0, d);
    check("R2 selector reset", d, 32'h8000_0000);
    for (int r = 0; r < NR; r++) read_inst("R10 reset zero", r, 0, 0, 1'b1);

    // R4 / R5: unicast sweep with full isolation readback
    for (int r = 0; r < NR; r++)
      for (int g = 0; g < NG; g++)
        for (int i = 0; i < NI; i++) begin
          logic [DW-1:0] v;
          v = 32'hA000_0000 + 32'(r) * 32'h1_0000 + 32'(g) * 32'h100 + 32'(i) + 32'd1;
          bwrite(0, steer(g, i, 1'b0));
          bwrite(2 + r, v);
          model[r][g*NI+i] = v;
          for (int gg = 0; gg < NG; gg++)
            for (int ii = 0; ii < NI; ii++)
              read_inst("R4 R5 unicast isolation", r, gg, ii, bit'((gg + ii) % 2));
        end

    // R3 / R6: multicast with partial presence
    present = 16'hA5C3;
    bwrite(0, steer(2, 1, 1'b1));
    bwrite(2, 32'h1234_5678);
    for (int k = 0; k < NC; k++) if (present[k]) model[0][k] = 32'h1234_5678;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NI; i++) read_inst("R3 R6 multicast partial", 0, g, i, 1'b0);
    for (int i = 0; i < NI; i++) read_inst("R6 other reg untouched", 1, 1, i, 1'b1);

    // R7: absent copies reappear with their old value
    present = '1;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NI; i++) read_inst("R7 absent kept", 0, g, i, 1'b1);

    // R6: unicast write to an absent copy is dropped
    present = '1; present[5] = 1'b0;
    bwrite(0, steer(1, 1, 1'b0));
    bwrite(3, 32'hDEAD_BEEF);
    bread(3, d);
    check("R6 absent read zero", d, 32'h0);
    present = '1;
    read_inst("R6 unicast drop", 1, 1, 1, 1'b0);

    // R6: out-of-range steering
    bwrite(0, steer(7, 0, 1'b0));
    bwrite(2, 32'h5555_AAAA);
    bread(2, d);
    check("R6 out of range read", d, 32'h0);
    bwrite(0, steer(0, 9, 1'b0));
    bread(2, d);
    check("R6 out of range instance", d, 32'h0);
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NI; i++) read_inst("R6 out of range write dropped", 0, g, i, 1'b1);

    // R1: unmapped address
    bwrite(0, steer(3, 2, 1'b0));
    bwrite(9, 32'hFFFF_FFFF);
    bread(9, d);
    check("R1 unmapped read", d, 32'h0);
    bread(0, d);
    check("R1 unmapped write ignored", d, steer(3, 2, 1'b0));
    read_inst("R1 regs untouched", 0, 3, 2, 1'b0);

    // R2: selector readback masks unused bits
    bwrite(0, 32'hFFFF_FFFF);
    bread(0, d);
    check("R2 selector fields", d, 32'h8000_00FF);

    // R8: semaphore acquire, contention, release
    bread(1, d); check("R8 first read acquires", d, 32'd1);
    bread(1, d); check("R8 contended read", d, 32'd0);
    bread(1, d); check("R8 still held", d, 32'd0);
    bwrite(1, 32'h0);
    bread(1, d); check("R8 write 0 no release", d, 32'd0);
    bwrite(1, 32'h1);
    bread(1, d); check("R8 release then acquire", d, 32'd1);
    bread(1, d); check("R8 held again", d, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule